// File: doc/BRIEF.md
# Raster-Scan Two-Dimensional Recursive Image Filter

This block filters a progressive raster-scanned image with a causal two-dimensional recursive (IIR) filter of order two along both axes. Each output pixel is a weighted sum of the current and earlier input pixels, plus the earlier output pixels, taken from the current line and the two lines above it. Nothing to the right of the current pixel or below its line is used. One pixel enters per cycle with `in_valid` high. Idle cycles may occur at any point. There is no backpressure. The filtered pixel appears exactly two cycles after its input.

The filter is split into three one-dimensional row sections, one for each vertical offset. All sections see the same current input and output samples and the same two-deep horizontal history. The partial sum of the deepest section passes through a line buffer into the middle section. The middle section's partial sum passes through a second line buffer into the output section. The horizontal history is cleared after every line. A two-state machine handles the vertical history. It is in `ST_FIRST_LINE` after reset and after the last pixel of a frame. It moves to `ST_LATER_LINE` after the last pixel of the first line. It returns to `ST_FIRST_LINE` on end of frame. While the machine is in `ST_FIRST_LINE`, both line-buffer reads are forced to zero.

Top module: `iir2d_raster`

## Requirements
- R1: While reset is held and after it is released, with no input, `out_valid` and `out_pix` are 0.
- R2: `out_valid` is high exactly two clock cycles after each cycle in which `in_valid` is high, and low otherwise.
- R3: Coefficient (k1 horizontal offset, k2 line offset) sits in bits [16*(3*k2+k1) +: 16] of `coef_a` (input weights) and `coef_b` (output weights). Each is signed Q2.13. The output is y(n1,n2) = Σ a(k1,k2)·x(n1−k1,n2−k2) + Σ b(k1,k2)·y(n1−k1,n2−k2), with samples outside the frame or before the line start taken as zero.
- R4: The weight b(0,0), slice 0 of `coef_b`, has no effect on any output.
- R5: The accumulated sum is rounded as floor((acc + 4096) / 8192) and then saturated to the range −32768..32767.
- R6: A pixel flagged with `in_eol` clears all horizontal history. The first pixel of the next line sees zero for earlier input and output samples on its own line.
- R7: A pixel flagged with `in_eof` is the last pixel of its frame and implies end of line. The first line of the next frame sees zero for every line above it.
- R8: The vertical terms use the pixel in the same column of earlier lines. All lines of one frame have the same length, which is at most `LINE_W`. Shorter lines are supported.
- R9: Cycles with `in_valid` low change neither the filter state nor the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present this cycle |
| in_pix | input | 16 | Signed input pixel |
| in_eol | input | 1 | Pixel is the last of its line |
| in_eof | input | 1 | Pixel is the last of its frame |
| coef_a | input | 144 | Nine signed Q2.13 input weights |
| coef_b | input | 144 | Nine signed Q2.13 output weights |
| out_valid | output | 1 | Output pixel present |
| out_pix | output | 16 | Signed filtered pixel |

## Verification
The bench builds the block with `LINE_W` set to 16. Full-width lines therefore wrap the column counter and use every line-buffer entry within a few hundred cycles. Frames with 10-pixel lines exercise addressing for lines shorter than the buffer. Frames of up to six lines expose the nested path through both line buffers. Back-to-back frames show whether vertical history leaks from one frame into the next.

// File: rtl/iir2d_pkg.sv
package iir2d_pkg;
    localparam int TAPS = 3;

    typedef enum logic {
        ST_FIRST_LINE,
        ST_LATER_LINE
    } row_state_e;
endpackage

// File: rtl/iir2d_row_sec.sv
module iir2d_row_sec
    import iir2d_pkg::*;
#(
    parameter int PIX_W  = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32
) (
    input  logic [TAPS*PIX_W-1:0]   x_taps,
    input  logic [TAPS*PIX_W-1:0]   y_taps,
    input  logic [TAPS*COEF_W-1:0]  a_row,
    input  logic [TAPS*COEF_W-1:0]  b_row,
    output logic signed [ACC_W-1:0] g_out
);
    always_comb begin
        logic signed [ACC_W-1:0] sum;
        logic signed [ACC_W-1:0] xe, ye, ae, be;
        sum = '0;
        for (int i = 0; i < TAPS; i++) begin
            xe  = ACC_W'($signed(x_taps[i*PIX_W +: PIX_W]));
            ye  = ACC_W'($signed(y_taps[i*PIX_W +: PIX_W]));
            ae  = ACC_W'($signed(a_row[i*COEF_W +: COEF_W]));
            be  = ACC_W'($signed(b_row[i*COEF_W +: COEF_W]));
            sum = sum + xe * ae + ye * be;
        end
        g_out = sum;
    end
endmodule

// File: rtl/iir2d_line_buf.sv
module iir2d_line_buf #(
    parameter int ACC_W = 32,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic signed [ACC_W-1:0] wr_data,
    input  logic                    rd_zero,
    output logic signed [ACC_W-1:0] rd_data
);
    logic signed [ACC_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wr_data;
        end
    end

    assign rd_data = rd_zero ? '0 : mem[addr];
endmodule

// File: rtl/iir2d_raster.sv
module iir2d_raster
    import iir2d_pkg::*;
#(
    parameter int PIX_W  = 16,
    parameter int COEF_W = 16,
    parameter int ACC_W  = 32,
    parameter int FRAC   = 13,
    parameter int LINE_W = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [PIX_W-1:0]          in_pix,
    input  logic                      in_eol,
    input  logic                      in_eof,
    input  logic [TAPS*TAPS*COEF_W-1:0] coef_a,
    input  logic [TAPS*TAPS*COEF_W-1:0] coef_b,
    output logic                      out_valid,
    output logic [PIX_W-1:0]          out_pix
);
    localparam int AW  = (LINE_W > 1) ? $clog2(LINE_W) : 1;
    localparam int ROW = TAPS * COEF_W;
    localparam logic signed [ACC_W:0] PMAX = (ACC_W+1)'((2**(PIX_W-1)) - 1);
    localparam logic signed [ACC_W:0] PMIN = -PMAX - 1;
    localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(2**(FRAC-1));

    // input stage
    logic             s1_v, s1_eol, s1_eof;
    logic [PIX_W-1:0] s1_x;
    // horizontal history shared by all row sections
    logic [PIX_W-1:0] xd1, xd2, yd1, yd2;
    logic [AW-1:0]    col;
    row_state_e       st, st_nx;
    logic             buf_zero;

    logic signed [ACC_W-1:0] g [TAPS];
    logic signed [ACC_W-1:0] rd_a, rd_b, p_mid, acc_y;
    logic signed [ACC_W:0]   rnd, shf;
    logic [PIX_W-1:0]        ycur;
    logic                    line_end;

    logic [TAPS*PIX_W-1:0] xtaps, ytaps_hist, ytaps_full;
    assign xtaps      = {xd2, xd1, s1_x};
    assign ytaps_hist = {yd2, yd1, {PIX_W{1'b0}}};
    assign ytaps_full = {yd2, yd1, ycur};
    assign line_end   = s1_eol | s1_eof;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_eol <= 1'b0;
            s1_eof <= 1'b0;
            s1_x   <= '0;
        end else begin
            s1_v   <= in_valid;
            s1_eol <= in_eol;
            s1_eof <= in_eof;
            s1_x   <= in_pix;
        end
    end

    // one row section per line offset; section 0 never sees the current output
    for (genvar k = 0; k < TAPS; k++) begin : g_sec
        iir2d_row_sec #(
            .PIX_W (PIX_W),
            .COEF_W(COEF_W),
            .ACC_W (ACC_W)
        ) sec_i (
            .x_taps(xtaps),
            .y_taps((k == 0) ? ytaps_hist : ytaps_full),
            .a_row (coef_a[k*ROW +: ROW]),
            .b_row (coef_b[k*ROW +: ROW]),
            .g_out (g[k])
        );
    end

    // buffer A carries the deepest partial sum, buffer B the middle one
    iir2d_line_buf #(.ACC_W(ACC_W), .DEPTH(LINE_W), .AW(AW)) buf_a_i (
        .clk(clk), .wr_en(s1_v), .addr(col), .wr_data(g[2]),
        .rd_zero(buf_zero), .rd_data(rd_a)
    );
    iir2d_line_buf #(.ACC_W(ACC_W), .DEPTH(LINE_W), .AW(AW)) buf_b_i (
        .clk(clk), .wr_en(s1_v), .addr(col), .wr_data(p_mid),
        .rd_zero(buf_zero), .rd_data(rd_b)
    );

    always_comb begin
        p_mid = g[1] + rd_a;
        acc_y = g[0] + rd_b;
        rnd   = {acc_y[ACC_W-1], acc_y} + HALF;
        shf   = rnd >>> FRAC;
        if (shf > PMAX)      ycur = PMAX[PIX_W-1:0];
        else if (shf < PMIN) ycur = PMIN[PIX_W-1:0];
        else                 ycur = shf[PIX_W-1:0];
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_FIRST_LINE;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_FIRST_LINE: if (s1_v && line_end) st_nx = s1_eof ? ST_FIRST_LINE : ST_LATER_LINE;
            ST_LATER_LINE: if (s1_v && s1_eof)   st_nx = ST_FIRST_LINE;
            default:       st_nx = ST_FIRST_LINE;
        endcase
    end

    // state outputs
    always_comb begin
        unique case (st)
            ST_FIRST_LINE: buf_zero = 1'b1;
            ST_LATER_LINE: buf_zero = 1'b0;
            default:       buf_zero = 1'b1;
        endcase
    end

    // horizontal history, column counter and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xd1 <= '0; xd2 <= '0; yd1 <= '0; yd2 <= '0;
            col <= '0;
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= s1_v;
            if (s1_v) begin
                out_pix <= ycur;
                if (line_end) begin
                    xd1 <= '0; xd2 <= '0; yd1 <= '0; yd2 <= '0;
                    col <= '0;
                end else begin
                    xd1 <= s1_x; xd2 <= xd1;
                    yd1 <= ycur; yd2 <= yd1;
                    col <= (col == AW'(LINE_W - 1)) ? '0 : col + 1'b1;
                end
            end
        end
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);
    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);
    assert_line_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && line_end) |=> (xd1 == '0 && xd2 == '0 && yd1 == '0 && yd2 == '0 && col == '0));
    assert_frame_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_v && s1_eof) |=> (st == ST_FIRST_LINE));
    assert_col_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col <= AW'(LINE_W - 1));
    assert_gap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_v |=> ($stable(col) && $stable(xd1) && $stable(yd1) && $stable(st)));
endmodule

// File: tb/iir2d_raster_tb_top.sv
`timescale 1ns/1ps
module iir2d_raster_tb_top;
    localparam int LW   = 16;
    localparam int MAXH = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [15:0]  in_pix = '0;
    logic         in_eol = 1'b0;
    logic         in_eof = 1'b0;
    logic [143:0] coef_a = '0;
    logic [143:0] coef_b = '0;
    logic         out_valid;
    logic [15:0]  out_pix;

    always #4 clk = ~clk;

    iir2d_raster #(.LINE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_eol(in_eol), .in_eof(in_eof), .coef_a(coef_a), .coef_b(coef_b),
        .out_valid(out_valid), .out_pix(out_pix)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    int    ca [3][3];
    int    cb [3][3];
    int    xm [MAXH][LW];
    int    ym [MAXH][LW];
    int    exp_q [$];
    string tag_q [$];
    logic  h1 = 1'b0, h2 = 1'b0;

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic apply_coefs();
        for (int k2 = 0; k2 < 3; k2++)
            for (int k1 = 0; k1 < 3; k1++) begin
                coef_a[16*(3*k2+k1) +: 16] = 16'(ca[k2][k1]);
                coef_b[16*(3*k2+k1) +: 16] = 16'(cb[k2][k1]);
            end
    endtask

    task automatic clear_coefs();
        for (int k2 = 0; k2 < 3; k2++)
            for (int k1 = 0; k1 < 3; k1++) begin
                ca[k2][k1] = 0;
                cb[k2][k1] = 0;
            end
    endtask

    task automatic rand_coefs();
        for (int k2 = 0; k2 < 3; k2++)
            for (int k1 = 0; k1 < 3; k1++) begin
                ca[k2][k1] = int'($urandom_range(0, 4000)) - 2000;
                cb[k2][k1] = int'($urandom_range(0, 4000)) - 2000;
            end
    endtask

    // behavioural difference equation, zero outside frame and before line start
    function automatic int model_px(int r, int c);
        longint acc = 0;
        for (int k2 = 0; k2 < 3; k2++)
            for (int k1 = 0; k1 < 3; k1++) begin
                if (r - k2 < 0 || c - k1 < 0) continue;
                acc += longint'(ca[k2][k1]) * xm[r-k2][c-k1];
                if (k1 != 0 || k2 != 0)
                    acc += longint'(cb[k2][k1]) * ym[r-k2][c-k1];
            end
        acc = (acc + 4096) >>> 13;
        if (acc > 32767)  acc = 32767;
        if (acc < -32768) acc = -32768;
        return int'(acc);
    endfunction

    function automatic int gen_px(int kind, int r, int c, int w);
        case (kind)
            0: return int'($urandom_range(0, 6000)) - 3000;
            1: return (r == 0 && c == 0) ? 8000 : 0;
            2: return ((r + c) % 2 == 0) ? 30000 : -30000;
            3: return int'($urandom_range(0, 14)) - 7;
            default: return (c == w - 1) ? 8000 : 0;
        endcase
    endfunction

    task automatic run_frame(int w, int h, int kind, int gap, string req);
        for (int r = 0; r < h; r++)
            for (int c = 0; c < w; c++) begin
                xm[r][c] = gen_px(kind, r, c, w);
                ym[r][c] = model_px(r, c);
                exp_q.push_back(ym[r][c]);
                tag_q.push_back(req);
                while (int'($urandom_range(0, 99)) < gap) begin
                    in_valid = 1'b0;
                    @(negedge clk);
                end
                in_valid = 1'b1;
                in_pix   = 16'(xm[r][c]);
                in_eol   = (c == w - 1);
                in_eof   = (c == w - 1) && (r == h - 1);
                @(negedge clk);
            end
        in_valid = 1'b0;
        in_eol   = 1'b0;
        in_eof   = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // latency history of in_valid
    always @(posedge clk) begin
        if (!rst_n) begin
            h1 <= 1'b0;
            h2 <= 1'b0;
        end else begin
            h1 <= in_valid;
            h2 <= h1;
        end
    end

    // monitor: latency and scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", int'(out_valid), int'(h2));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check("R2", 1, 0);
                end else begin
                    check(tag_q.pop_front(), int'($signed(out_pix)), exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        clear_coefs();
        apply_coefs();
        repeat (4) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_pix), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_pix), 0);

        // R3: random weights, random and impulse images, full width
        rand_coefs(); apply_coefs();
        run_frame(LW, 5, 0, 20, "R3");
        run_frame(LW, 4, 1, 10, "R3");
        drain();

        // R4: output weight at offset (0,0) changed, no effect expected
        rand_coefs(); cb[0][0] = 0; apply_coefs();
        run_frame(LW, 3, 0, 10, "R4");
        drain();
        cb[0][0] = 7000; apply_coefs();
        run_frame(LW, 3, 0, 10, "R4");
        drain();

        // R5: saturation, then rounding of small odd products
        clear_coefs(); ca[0][0] = 16384; apply_coefs();
        run_frame(LW, 2, 2, 0, "R5");
        drain();
        clear_coefs(); ca[0][0] = 4096; ca[0][1] = -4096; apply_coefs();
        run_frame(LW, 3, 3, 0, "R5");
        drain();

        // R6: horizontal-only recursion with energy at each line end
        clear_coefs(); ca[0][1] = 8192; cb[0][1] = 4000; ca[0][2] = -2000; cb[0][2] = 1500;
        apply_coefs();
        run_frame(LW, 4, 4, 10, "R6");
        drain();

        // R7: vertical recursion over back-to-back frames
        clear_coefs(); ca[1][0] = 8192; cb[1][0] = 6000; cb[2][0] = -2000; ca[2][0] = 3000;
        cb[1][1] = 1000; apply_coefs();
        run_frame(LW, 4, 0, 0, "R7");
        run_frame(LW, 4, 1, 0, "R7");
        run_frame(LW, 3, 1, 5, "R7");
        drain();

        // R8: short lines, deep frames
        rand_coefs(); apply_coefs();
        run_frame(10, 6, 1, 10, "R8");
        run_frame(10, 6, 0, 10, "R8");
        drain();

        // R9: heavy idle gaps
        rand_coefs(); apply_coefs();
        run_frame(LW, 4, 0, 70, "R9");
        drain();

        check("R2", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule